// File: doc/BRIEF.md
# One-Wire Node Address Fetch Controller

This block is the master for one open-drain one-wire line. A single-cycle `start` request makes it run one complete transaction with one attached memory device. The transaction has four parts. First comes a long reset pulse, and the device's presence answer is sampled. A fixed four-byte command stream then tells the lone device to return its memory from address zero. The controller then reads one checksum byte, which it discards, followed by 28 data bytes.

While the data streams in, the controller compares sixteen of the bytes against a 128-bit ASCII signature held in a parameter, and it keeps three other bytes. When the transaction ends it presents a 48-bit node address built from a fixed 24-bit prefix and the three kept bytes, taken in reverse order. It also presents a 2-bit status code and raises `done` for one clock. If no device answers, or if the signature does not match, the address falls back to the prefix followed by all-ones.

All line timings are whole microseconds. A prescaler driven by the `CLK_MHZ` parameter produces a 1 µs tick, and a down-counter loaded per phase counts these ticks. The line is modelled as a drive-low enable (`lineDriveLow`) and a sense input (`lineSense`). The sense input is high when nobody pulls the line down.

Top module: `owMacFetch`

## Requirements
- R1: After reset, `done` is 0, `status` is 0, `macAddr` is 0 and the line is released. With no `start`, the line stays released.
- R2: A transaction opens with the line driven low for `RESET_LOW_US` (500 µs). The line is then released, and it is sampled `PRESENCE_WAIT_US` (60 µs) after the release, where a low sample means a device is present. The line then stays released for a further `RESET_IDLE_US` (500 µs).
- R3: When no device is present, `status` is 1, `macAddr` is 48'h00E0EE_FFFFFF, and no write slot is issued after the reset pulse.
- R4: When a device is present, the bytes 0xCC, 0xF0, 0x00, 0x00 are written in that order, each least-significant bit first. After them, 29 bytes (232 read slots) are read, and the first byte read is discarded.
- R5: Each write slot has three parts. The line is released for `SETTLE_US` (3 µs) and then driven low for `WRITE_LOW_US` (3 µs). For the remaining `WRITE_BIT_US` (60 µs) it is released for a 1 bit or kept low for a 0 bit. As a result, a 1-bit low pulse lasts at most 15 µs and a 0-bit low pulse lasts at least 60 µs.
- R6: Each read slot has four parts. The line is released for 3 µs, driven low for `READ_LOW_US` (1 µs), and then released. It is sampled `READ_SAMPLE_US` (10 µs) after the release, and the slot waits `READ_RECOVER_US` (60 µs) more. The sampled bit enters at the top of the receive byte, so bytes arrive least-significant bit first.
- R7: Data bytes 11 to 26 (data byte 0 is the first byte after the discarded one) are compared with `SIGNATURE`. Data byte 11 is compared with bits [127:120] and data byte 26 with bits [7:0]. Data bytes outside 5..7 and 11..26 have no effect on the outputs.
- R8: When all sixteen bytes match, `status` is 0 and `macAddr` is {`ADDR_PREFIX` (24'h00E0EE), data byte 7, data byte 6, data byte 5}, with data byte 7 in bits [23:16].
- R9: A mismatch in any one of data bytes 11 to 26 gives `status` 2 and `macAddr` 48'h00E0EE_FFFFFF.
- R10: `done` is high for exactly one clock per transaction. `macAddr` and `status` carry the new result in that clock and hold it until the next `done`.
- R11: A `start` that arrives while a transaction is running is ignored, so each accepted start yields exactly one reset pulse and one `done`.
- R12: All timing is counted in ticks of `CLK_MHZ` clocks. A phase of N µs therefore lasts N·`CLK_MHZ` clocks plus one clock for the phase change. At `CLK_MHZ` = 2 the reset pulse lasts 998 to 1004 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one transaction (sampled when idle) |
| lineSense | input | 1 | Level seen on the one-wire line (1 = released) |
| lineDriveLow | output | 1 | 1 pulls the one-wire line low |
| done | output | 1 | One-clock pulse at completion |
| macAddr | output | 48 | Fetched or fallback node address |
| status | output | 2 | 0 = valid, 1 = no device, 2 = signature mismatch |

## Verification
Two events can land on the same clock. The first is at a command-byte boundary: the shift of the finished command byte and the load of the next one happen together. The bench provokes this with the command stream itself and judges it by decoding all 32 low-pulse widths back into bits, which must read 0xCC, 0xF0, 0x00, 0x00. The second case is a `start` pulse injected part-way through a reset/idle sequence that is already running. The bench judges it by counting reset pulses and `done` pulses, which must each be exactly one, and by checking that the address from that transaction is still correct.

// File: rtl/owMacPkg.sv
package owMacPkg;

  localparam int CMD_BYTES  = 4;
  localparam int RX_BYTES   = 29;  // checksum byte + 28 data bytes
  localparam int SIG_FIRST  = 11;
  localparam int SIG_LEN    = 16;
  localparam int ADDR_FIRST = 5;
  localparam int ADDR_LEN   = 3;
  localparam int TX_IDX_W   = $clog2(CMD_BYTES);
  localparam int RX_IDX_W   = $clog2(RX_BYTES);
  localparam int ADDR_W     = 24 + 8 * ADDR_LEN;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_NODEV  = 2'd1,
    ST_BADSIG = 2'd2
  } fetchStatus_e;

  typedef enum logic [3:0] {
    TS_RSTLOW, TS_PRESWAIT, TS_IDLEGAP, TS_SETTLE,
    TS_WLOW, TS_WBIT, TS_RLOW, TS_RSAMP, TS_RREC
  } timeSel_e;

  typedef struct packed {
    logic                timerLoad;
    timeSel_e            timerSel;
    logic                txLoad;
    logic [TX_IDX_W-1:0] txIdx;
    logic                txShift;
    logic                rxShift;
    logic                commit;
    logic [RX_IDX_W-1:0] commitIdx;
    logic                clearSig;
    logic                publish;
    logic                noDevice;
  } ctrlStrobe_t;

  function automatic logic [7:0] cmdByte(input logic [TX_IDX_W-1:0] idx);
    case (idx)
      TX_IDX_W'(0): cmdByte = 8'hCC;
      TX_IDX_W'(1): cmdByte = 8'hF0;
      default:      cmdByte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/owFetchDatapath.sv
module owFetchDatapath
  import owMacPkg::*;
#(
  parameter int           CLK_MHZ          = 250,
  parameter int           RESET_LOW_US     = 500,
  parameter int           PRESENCE_WAIT_US = 60,
  parameter int           RESET_IDLE_US    = 500,
  parameter int           SETTLE_US        = 3,
  parameter int           WRITE_LOW_US     = 3,
  parameter int           WRITE_BIT_US     = 60,
  parameter int           READ_LOW_US      = 1,
  parameter int           READ_SAMPLE_US   = 10,
  parameter int           READ_RECOVER_US  = 60,
  parameter int           SYNC_STAGES      = 2,
  parameter logic [127:0] SIGNATURE        = "ONEWIRE-MACADDR!",
  parameter logic [23:0]  ADDR_PREFIX      = 24'h00E0EE
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              lineSense,
  output logic              lineSync,
  output logic              timerDone,
  output logic              txBit,
  output logic [ADDR_W-1:0] macAddr,
  output logic [1:0]        status
);

  localparam int PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam int T_SUM = RESET_LOW_US + PRESENCE_WAIT_US + RESET_IDLE_US + SETTLE_US
                       + WRITE_LOW_US + WRITE_BIT_US + READ_LOW_US + READ_SAMPLE_US
                       + READ_RECOVER_US;
  localparam int T_W   = $clog2(T_SUM + 1);

  // input synchronizer, idle level high
  logic [SYNC_STAGES-1:0] syncQ;
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[0] <= 1'b1;
        else       syncQ[0] <= lineSense;
    end else begin : gRest
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= syncQ[g-1];
    end
  end
  assign lineSync = syncQ[SYNC_STAGES-1];

  // microsecond prescaler, restarted on each phase load
  logic [PRE_W-1:0] preCnt;
  logic             tick;
  assign tick = (preCnt == PRE_W'(CLK_MHZ - 1));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                          preCnt <= '0;
    else if (strobe.timerLoad || tick)  preCnt <= '0;
    else                                preCnt <= preCnt + 1'b1;

  // phase timer
  logic [T_W-1:0] loadVal;
  logic [T_W-1:0] timerCnt;

  always_comb begin
    case (strobe.timerSel)
      TS_RSTLOW:   loadVal = T_W'(RESET_LOW_US);
      TS_PRESWAIT: loadVal = T_W'(PRESENCE_WAIT_US);
      TS_IDLEGAP:  loadVal = T_W'(RESET_IDLE_US);
      TS_WLOW:     loadVal = T_W'(WRITE_LOW_US);
      TS_WBIT:     loadVal = T_W'(WRITE_BIT_US);
      TS_RLOW:     loadVal = T_W'(READ_LOW_US);
      TS_RSAMP:    loadVal = T_W'(READ_SAMPLE_US);
      TS_RREC:     loadVal = T_W'(READ_RECOVER_US);
      default:     loadVal = T_W'(SETTLE_US);
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                          timerCnt <= '0;
    else if (strobe.timerLoad)          timerCnt <= loadVal;
    else if (tick && timerCnt != '0)    timerCnt <= timerCnt - 1'b1;

  assign timerDone = (timerCnt == '0);

  // transmit shifter
  logic [7:0] txReg;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               txReg <= '0;
    else if (strobe.txLoad)  txReg <= cmdByte(strobe.txIdx);
    else if (strobe.txShift) txReg <= {1'b0, txReg[7:1]};
  assign txBit = txReg[0];

  // receive shifter, new bit at the top
  logic [7:0] rxReg;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               rxReg <= '0;
    else if (strobe.rxShift) rxReg <= {lineSync, rxReg[7:1]};

  // signature compare on the fly
  function automatic logic [7:0] sigByteAt(input int k);
    return SIGNATURE[8*(SIG_LEN-1-k) +: 8];
  endfunction

  logic sigOk;
  logic sigHit;
  assign sigHit = strobe.commit
               && (int'(strobe.commitIdx) >= SIG_FIRST)
               && (int'(strobe.commitIdx) <  SIG_FIRST + SIG_LEN);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                 sigOk <= 1'b0;
    else if (strobe.clearSig)  sigOk <= 1'b1;
    else if (sigHit && rxReg != sigByteAt(int'(strobe.commitIdx) - SIG_FIRST))
                               sigOk <= 1'b0;

  // captured address bytes
  logic [7:0] payload [ADDR_LEN];
  for (genvar g = 0; g < ADDR_LEN; g++) begin : gPay
    always_ff @(posedge clk or negedge rstN)
      if (!rstN) payload[g] <= '0;
      else if (strobe.commit && int'(strobe.commitIdx) == ADDR_FIRST + g)
        payload[g] <= rxReg;
  end

  logic [8*ADDR_LEN-1:0] payloadRev;
  always_comb
    for (int i = 0; i < ADDR_LEN; i++)
      payloadRev[8*i +: 8] = payload[i];

  // result registers
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      macAddr <= '0;
      status  <= 2'(ST_OK);
    end else if (strobe.publish) begin
      if (strobe.noDevice) begin
        status  <= 2'(ST_NODEV);
        macAddr <= {ADDR_PREFIX, {(8*ADDR_LEN){1'b1}}};
      end else if (!sigOk) begin
        status  <= 2'(ST_BADSIG);
        macAddr <= {ADDR_PREFIX, {(8*ADDR_LEN){1'b1}}};
      end else begin
        status  <= 2'(ST_OK);
        macAddr <= {ADDR_PREFIX, payloadRev};
      end
    end

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.publish |=> ($stable(status) && $stable(macAddr)));

  // R9
  fallback_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status != 2'(ST_OK)) |-> (macAddr[8*ADDR_LEN-1:0] == {(8*ADDR_LEN){1'b1}}));

  // R12
  timer_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.timerLoad |=> !timerDone);

  if (CLK_MHZ > 1) begin : gTickChk
    // R12
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
      tick |=> !tick);
  end

endmodule

// File: rtl/owFetchCtrl.sv
module owFetchCtrl
  import owMacPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        timerDone,
  input  logic        txBit,
  input  logic        lineSync,
  output ctrlStrobe_t strobe,
  output logic        lineDriveLow,
  output logic        done
);

  typedef enum logic [3:0] {
    S_IDLE, S_RST_LOW, S_RST_WAIT, S_RST_IDLE,
    S_W_PRE, S_W_LOW, S_W_BIT,
    S_R_PRE, S_R_LOW, S_R_SAMP, S_R_REC,
    S_FINISH
  } state_e;

  state_e              state, stateNext;
  logic [2:0]          bitCnt, bitNext;
  logic [TX_IDX_W-1:0] txCnt, txNext;
  logic [RX_IDX_W-1:0] rxCnt, rxNext;
  logic                presentReg, presNext;
  logic                driveNext;
  ctrlStrobe_t         stb;

  always_comb begin
    stateNext = state;
    bitNext   = bitCnt;
    txNext    = txCnt;
    rxNext    = rxCnt;
    presNext  = presentReg;
    stb       = '0;
    case (state)
      S_IDLE:
        if (start) begin
          stateNext = S_RST_LOW;
          stb.timerLoad = 1'b1; stb.timerSel = TS_RSTLOW;
          stb.clearSig  = 1'b1;
        end
      S_RST_LOW:
        if (timerDone) begin
          stateNext = S_RST_WAIT;
          stb.timerLoad = 1'b1; stb.timerSel = TS_PRESWAIT;
        end
      S_RST_WAIT:
        if (timerDone) begin
          presNext  = !lineSync;
          stateNext = S_RST_IDLE;
          stb.timerLoad = 1'b1; stb.timerSel = TS_IDLEGAP;
        end
      S_RST_IDLE:
        if (timerDone) begin
          if (presentReg) begin
            stateNext = S_W_PRE;
            stb.timerLoad = 1'b1; stb.timerSel = TS_SETTLE;
            stb.txLoad = 1'b1; stb.txIdx = '0;
            txNext  = '0;
            bitNext = '0;
          end else begin
            stateNext = S_FINISH;
          end
        end
      S_W_PRE:
        if (timerDone) begin
          stateNext = S_W_LOW;
          stb.timerLoad = 1'b1; stb.timerSel = TS_WLOW;
        end
      S_W_LOW:
        if (timerDone) begin
          stateNext = S_W_BIT;
          stb.timerLoad = 1'b1; stb.timerSel = TS_WBIT;
        end
      S_W_BIT:
        if (timerDone) begin
          stb.txShift   = 1'b1;
          stb.timerLoad = 1'b1; stb.timerSel = TS_SETTLE;
          if (bitCnt == 3'd7) begin
            bitNext = '0;
            if (txCnt == TX_IDX_W'(CMD_BYTES - 1)) begin
              stateNext = S_R_PRE;
              rxNext    = '0;
            end else begin
              stateNext  = S_W_PRE;
              txNext     = txCnt + 1'b1;
              stb.txLoad = 1'b1;
              stb.txIdx  = txCnt + 1'b1;
            end
          end else begin
            bitNext   = bitCnt + 1'b1;
            stateNext = S_W_PRE;
          end
        end
      S_R_PRE:
        if (timerDone) begin
          stateNext = S_R_LOW;
          stb.timerLoad = 1'b1; stb.timerSel = TS_RLOW;
        end
      S_R_LOW:
        if (timerDone) begin
          stateNext = S_R_SAMP;
          stb.timerLoad = 1'b1; stb.timerSel = TS_RSAMP;
        end
      S_R_SAMP:
        if (timerDone) begin
          stb.rxShift = 1'b1;
          stateNext   = S_R_REC;
          stb.timerLoad = 1'b1; stb.timerSel = TS_RREC;
        end
      S_R_REC:
        if (timerDone) begin
          if (bitCnt == 3'd7) begin
            bitNext       = '0;
            stb.commit    = (rxCnt != '0);
            stb.commitIdx = rxCnt - 1'b1;
            if (rxCnt == RX_IDX_W'(RX_BYTES - 1)) begin
              stateNext = S_FINISH;
            end else begin
              rxNext    = rxCnt + 1'b1;
              stateNext = S_R_PRE;
              stb.timerLoad = 1'b1; stb.timerSel = TS_SETTLE;
            end
          end else begin
            bitNext   = bitCnt + 1'b1;
            stateNext = S_R_PRE;
            stb.timerLoad = 1'b1; stb.timerSel = TS_SETTLE;
          end
        end
      S_FINISH: begin
        stb.publish  = 1'b1;
        stb.noDevice = !presentReg;
        stateNext    = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    case (stateNext)
      S_RST_LOW, S_W_LOW, S_R_LOW: driveNext = 1'b1;
      S_W_BIT:                     driveNext = !txBit;
      default:                     driveNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state        <= S_IDLE;
      bitCnt       <= '0;
      txCnt        <= '0;
      rxCnt        <= '0;
      presentReg   <= 1'b0;
      lineDriveLow <= 1'b0;
      done         <= 1'b0;
    end else begin
      state        <= stateNext;
      bitCnt       <= bitNext;
      txCnt        <= txNext;
      rxCnt        <= rxNext;
      presentReg   <= presNext;
      lineDriveLow <= driveNext;
      done         <= (state == S_FINISH);
    end

  assign strobe = stb;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  nodev_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_W_PRE) |-> presentReg);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {S_W_PRE, S_R_PRE, S_R_SAMP, S_R_REC, S_RST_WAIT, S_RST_IDLE})
      |-> !lineDriveLow);

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && state != S_RST_LOW) |=> (state != S_RST_LOW));

  // R4
  byte_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(rxCnt) <= RX_BYTES - 1);

endmodule

// File: rtl/owMacFetch.sv
module owMacFetch
  import owMacPkg::*;
#(
  parameter int           CLK_MHZ          = 250,
  parameter int           RESET_LOW_US     = 500,
  parameter int           PRESENCE_WAIT_US = 60,
  parameter int           RESET_IDLE_US    = 500,
  parameter int           SETTLE_US        = 3,
  parameter int           WRITE_LOW_US     = 3,
  parameter int           WRITE_BIT_US     = 60,
  parameter int           READ_LOW_US      = 1,
  parameter int           READ_SAMPLE_US   = 10,
  parameter int           READ_RECOVER_US  = 60,
  parameter int           SYNC_STAGES      = 2,
  parameter logic [127:0] SIGNATURE        = "ONEWIRE-MACADDR!",
  parameter logic [23:0]  ADDR_PREFIX      = 24'h00E0EE
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        lineSense,
  output logic        lineDriveLow,
  output logic        done,
  output logic [47:0] macAddr,
  output logic [1:0]  status
);

  ctrlStrobe_t strobe;
  logic        timerDone;
  logic        txBit;
  logic        lineSync;

  owFetchCtrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .timerDone    (timerDone),
    .txBit        (txBit),
    .lineSync     (lineSync),
    .strobe       (strobe),
    .lineDriveLow (lineDriveLow),
    .done         (done)
  );

  owFetchDatapath #(
    .CLK_MHZ          (CLK_MHZ),
    .RESET_LOW_US     (RESET_LOW_US),
    .PRESENCE_WAIT_US (PRESENCE_WAIT_US),
    .RESET_IDLE_US    (RESET_IDLE_US),
    .SETTLE_US        (SETTLE_US),
    .WRITE_LOW_US     (WRITE_LOW_US),
    .WRITE_BIT_US     (WRITE_BIT_US),
    .READ_LOW_US      (READ_LOW_US),
    .READ_SAMPLE_US   (READ_SAMPLE_US),
    .READ_RECOVER_US  (READ_RECOVER_US),
    .SYNC_STAGES      (SYNC_STAGES),
    .SIGNATURE        (SIGNATURE),
    .ADDR_PREFIX      (ADDR_PREFIX)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lineSense (lineSense),
    .lineSync  (lineSync),
    .timerDone (timerDone),
    .txBit     (txBit),
    .macAddr   (macAddr),
    .status    (status)
  );

endmodule

// File: tb/owMacFetch_tb.sv
module owMacFetch_tb_top;

  localparam logic [127:0] SIG = "ONEWIRE-MACADDR!";
  localparam int WATCHDOG = 195000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        lineDriveLow;
  logic        done;
  logic [47:0] macAddr;
  logic [1:0]  status;
  logic        slaveLow = 1'b0;
  logic        lineSense;

  assign lineSense = !(lineDriveLow || slaveLow);

  always #2 clk = ~clk;

  owMacFetch #(.CLK_MHZ(2)) dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .lineSense    (lineSense),
    .lineDriveLow (lineDriveLow),
    .done         (done),
    .macAddr      (macAddr),
    .status       (status)
  );

  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  bit         slavePresent = 1'b1;
  logic [7:0] rdMem [29];
  int  lowCnt = 0, presCnt = -1, holdCnt = 0;
  int  writeBits = 0, readBits = 0, resetCount = 0, lastResetLen = 0;
  int  fallCount = 0, doneCount = 0, doneRun = 0, maxDoneRun = 0;
  int  maxOneLow = 0, minZeroLow = 1000000, maxReadLow = 0;
  logic [31:0] cmdRx = '0;
  bit  prevDrive = 1'b0;

  always @(negedge clk) begin
    if (lineDriveLow && !prevDrive) begin
      fallCount++;
      if (writeBits == 32 && readBits < 232) begin
        if (rdMem[readBits / 8][readBits % 8] == 1'b0) holdCnt = 40;
        readBits++;
      end
    end
    if (lineDriveLow) lowCnt++;
    else if (lowCnt > 0) begin
      if (lowCnt >= 600) begin
        resetCount++; lastResetLen = lowCnt;
        writeBits = 0; readBits = 0; presCnt = 0;
      end else if (writeBits < 32) begin
        cmdRx[writeBits] = (lowCnt < 60);
        if (lowCnt < 60) begin if (lowCnt > maxOneLow) maxOneLow = lowCnt; end
        else if (lowCnt < minZeroLow) minZeroLow = lowCnt;
        writeBits++;
      end else if (lowCnt > maxReadLow) maxReadLow = lowCnt;
      lowCnt = 0;
    end
    prevDrive = lineDriveLow;
    if (done) begin doneCount++; doneRun++; if (doneRun > maxDoneRun) maxDoneRun = doneRun; end
    else doneRun = 0;
    if (holdCnt > 0) holdCnt--;
    if (presCnt >= 0 && presCnt < 1000) presCnt++;
    slaveLow = (holdCnt > 0) ||
               (slavePresent && presCnt >= 30 && presCnt <= 200);
  end

  // data bytes, index 0 = first byte after checksum
  logic [7:0] dataB [28];

  task automatic loadData(input int badIdx);
    for (int i = 0; i < 28; i++) dataB[i] = 8'h80 + 8'(i * 7);
    for (int k = 0; k < 16; k++) dataB[11 + k] = SIG[8*(15-k) +: 8];
    dataB[5] = 8'h3C; dataB[6] = 8'h5A; dataB[7] = 8'hC1;
    dataB[10] = 8'hEE; dataB[27] = 8'h00;
    if (badIdx >= 0) dataB[badIdx] = dataB[badIdx] ^ 8'h20;
    rdMem[0] = 8'hA7;
    for (int i = 0; i < 28; i++) rdMem[i + 1] = dataB[i];
  endtask

  task automatic runTxn(input bit poke, output logic [47:0] gotAddr,
                        output logic [1:0] gotStat);
    int waited;
    resetCount = 0; doneCount = 0; maxDoneRun = 0; writeBits = 0; readBits = 0;
    cmdRx = '0; maxOneLow = 0; minZeroLow = 1000000; maxReadLow = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (1500) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 60000) begin @(negedge clk); waited++; end
    gotAddr = macAddr;
    gotStat = status;
    repeat (6) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    int falls;
    chk("R1", "done after reset", 64'(done), 64'd0);
    chk("R1", "status after reset", 64'(status), 64'd0);
    chk("R1", "address after reset", 64'(macAddr), 64'd0);
    falls = fallCount;
    repeat (200) @(negedge clk);
    chk("R1", "line idle without start", 64'(fallCount - falls), 64'd0);
    chk("R1", "line released", 64'(lineDriveLow), 64'd0);
  endtask

  task automatic testNoDevice();
    logic [47:0] a; logic [1:0] s;
    slavePresent = 1'b0;
    loadData(-1);
    runTxn(1'b0, a, s);
    chk("R3", "status no device", 64'(s), 64'd1);
    chk("R3", "fallback address", 64'(a), 64'h00E0EEFFFFFF);
    chk("R3", "no write slots", 64'(writeBits), 64'd0);
    chk("R12", "reset low length in range",
        64'(lastResetLen >= 998 && lastResetLen <= 1004), 64'd1);
    chk("R10", "done width", 64'(maxDoneRun), 64'd1);
    slavePresent = 1'b1;
  endtask

  task automatic testGood();
    logic [47:0] a; logic [1:0] s;
    loadData(-1);
    runTxn(1'b1, a, s);
    chk("R8", "status match", 64'(s), 64'd0);
    chk("R8", "assembled address", 64'(a), {16'h0, 24'h00E0EE, dataB[7], dataB[6], dataB[5]});
    chk("R4", "command bits", 64'(cmdRx), 64'h0000_0000_0000_F0CC);
    chk("R4", "read slot count", 64'(readBits), 64'd232);
    chk("R2", "reset low at least 480us", 64'(lastResetLen >= 960), 64'd1);
    chk("R5", "one-bit low short", 64'(maxOneLow <= 30 && maxOneLow > 0), 64'd1);
    chk("R5", "zero-bit low long", 64'(minZeroLow >= 120), 64'd1);
    chk("R6", "read low brief", 64'(maxReadLow <= 4 && maxReadLow > 0), 64'd1);
    chk("R11", "one reset per start", 64'(resetCount), 64'd1);
    chk("R11", "one done per start", 64'(doneCount), 64'd1);
    chk("R10", "done width", 64'(maxDoneRun), 64'd1);
    chk("R7", "bytes 10 and 27 ignored", 64'(s), 64'd0);
    repeat (100) @(negedge clk);
    chk("R10", "address held", 64'(macAddr), 64'(a));
  endtask

  task automatic testBad(input int idx);
    logic [47:0] a; logic [1:0] s;
    loadData(idx);
    runTxn(1'b0, a, s);
    chk("R9", $sformatf("status mismatch at byte %0d", idx), 64'(s), 64'd2);
    chk("R9", $sformatf("fallback address at byte %0d", idx), 64'(a), 64'h00E0EEFFFFFF);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testNoDevice();
    testGood();
    testBad(26);
    testBad(11);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFail++;
    $display("FAIL R10 watchdog: actual no completion expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule